// File: doc/BRIEF.md
# Multi-Source Interrupt Level Arbiter

This block collects interrupt requests from ten sources and drives the highest pending priority level to a processor on a 3-bit output. The sources are a watchdog, a periodic timer, a communications engine and seven external request pins. The watchdog always requests at level 7. External pin n requests at level n. The timer and the communications engine each use a level taken from a configuration input. Each source also has a 4-bit arbitration ID, taken from a flat configuration vector.

Several sources may request at the same level at the same time, and this is a legal configuration. The tie is not resolved while the requests wait. It is resolved only when the processor starts an acknowledge for a level. The acknowledge runs through a three-state machine: `ACK_IDLE`, `ACK_CMP` and `ACK_RESP`. An accepted request moves `ACK_IDLE` to `ACK_CMP`. In `ACK_CMP` the acknowledged level is compared against every pending source and the best one is registered. The machine then always moves to `ACK_RESP`, which presents the result for one cycle. From `ACK_RESP` it always returns to `ACK_IDLE`.

The result is either a winner or a spurious indication. A winner is reported as its source code and its arbitration ID. If the winner is an internal source, its request is retired. When every source sits on a different level, the acknowledged level alone decides the winner.

Top module: `irq_level_arbiter`

## Requirements
- R1: `ipl_o` equals the highest level among all pending requests. It is 0 when nothing is pending.
- R2: A pending watchdog request always counts as level 7.
- R3: External pin k of `ext_irq_i` (bit k-1) requests at level k. The pins are sampled at every clock edge and are not latched. A pin change shows on `ipl_o` one cycle later, and so does its removal.
- R4: The timer and the communications engine request at the level given by `tmr_level_i` and `com_level_i`. A level of 0 makes that source contribute nothing.
- R5: A one-cycle pulse on `wdg_pulse_i`, `tmr_pulse_i` or `com_pulse_i` sets a pending request. That request stays set until the source wins an acknowledge.
- R6: The acknowledge sequence follows the clock edges as below.
  - `ack_req_i` with `ack_level_i` is accepted only in `ACK_IDLE`.
  - At the accepting edge the machine enters `ACK_CMP`, and `ack_done_o` stays low.
  - At the next edge it enters `ACK_RESP`, and `ack_done_o` is high for exactly that one cycle.
  - `ack_req_i` and `ack_level_i` are ignored while the machine is busy.
- R7: Among the sources pending at the acknowledged level, the one with the highest arbitration ID wins. The ID of source s is `arb_id_i[4s+3:4s]`. If two IDs are equal, the higher source code wins.
  - Source codes 0 to 6 are external pins 1 to 7.
  - Code 7 is the timer, code 8 the communications engine and code 9 the watchdog.
  - `ack_src_o` carries the winner's code and `ack_id_o` its ID.
- R8: When only one source is pending at the acknowledged level, that source wins whatever its ID.
- R9: If no source is pending at the acknowledged level, including level 0, the response sets `ack_spurious_o`. It also drives `ack_src_o` and `ack_id_o` to 0 and leaves every request unchanged.
- R10: An internal winner's request is cleared at the edge that ends `ACK_RESP`. A set pulse in that same cycle keeps the request pending. An external winner is never cleared by the block.
- R11: After reset nothing is pending, `ipl_o` is 0, and all acknowledge outputs are 0. Outside `ACK_RESP`, `ack_spurious_o`, `ack_src_o` and `ack_id_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 7 | External request pins; bit k-1 requests level k |
| wdg_pulse_i | input | 1 | Watchdog request pulse |
| tmr_pulse_i | input | 1 | Periodic timer request pulse |
| com_pulse_i | input | 1 | Communications engine request pulse |
| tmr_level_i | input | 3 | Timer request level, 0 disables |
| com_level_i | input | 3 | Communications engine request level, 0 disables |
| arb_id_i | input | 40 | Arbitration IDs, 4 bits per source code |
| ipl_o | output | 3 | Highest pending level |
| ack_req_i | input | 1 | Start an acknowledge |
| ack_level_i | input | 3 | Level being acknowledged |
| ack_done_o | output | 1 | Acknowledge result valid |
| ack_spurious_o | output | 1 | No requester at the acknowledged level |
| ack_src_o | output | 4 | Winning source code |
| ack_id_o | output | 4 | Winning arbitration ID |

## Verification
A wrong pending bit shows on `ipl_o` in the cycle after the edge that corrupted it. It also shows as a wrong or spurious winner at the next acknowledge of its level, two edges after the request. A fault in the compare stage or the scan order shows only in the single `ACK_RESP` cycle, as a wrong source code or ID. A fault in the retire logic shows one edge after that cycle, as a level that stays up or disappears on `ipl_o`. Stimulus combines random pin patterns, pulses, levels and ID permutations with directed ties, equal IDs, spurious levels, busy-time requests and set pulses during the retire cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W   = 3;
    localparam int ID_W    = 4;
    localparam int N_EXT   = 7;
    localparam int N_INT   = 3;
    localparam int N_SRC   = N_EXT + N_INT;
    localparam int SRC_W   = $clog2(N_SRC);
    localparam int SRC_TMR = N_EXT;
    localparam int SRC_COM = N_EXT + 1;
    localparam int SRC_WDG = N_EXT + 2;
    localparam int LVL_TOP = (1 << LVL_W) - 1;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [ID_W-1:0]  arb_id_t;
    typedef logic [SRC_W-1:0] src_t;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_CMP,
        ACK_RESP
    } ack_state_e;
endpackage

// File: rtl/irq_src_pending.sv
module irq_src_pending
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic [N_INT-1:0] set_i,
    input  logic [N_INT-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_EXT-1:0] ext_q;
    logic [N_INT-1:0] int_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= ext_irq_i;
    end

    for (genvar k = 0; k < N_INT; k++) begin : g_int
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) int_q[k] <= 1'b0;
            else        int_q[k] <= set_i[k] | (int_q[k] & ~clr_i[k]);
        end

        // R5: held until cleared
        a_r5_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (int_q[k] && !clr_i[k]) |=> int_q[k]);
        // R10: a clear without a set retires the request
        a_r10_clear_retires: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !int_q[k]);
        // R10: set wins over clear
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> int_q[k]);
    end

    assign pend_o = {int_q, ext_q};
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_i,
    input  lvl_t             tmr_level_i,
    input  lvl_t             com_level_i,
    output lvl_t             eff_lvl_o [N_SRC],
    output lvl_t             ipl_o
);
    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        assign eff_lvl_o[k] = pend_i[k] ? lvl_t'(k + 1) : '0;
    end
    assign eff_lvl_o[SRC_TMR] = pend_i[SRC_TMR] ? tmr_level_i : '0;
    assign eff_lvl_o[SRC_COM] = pend_i[SRC_COM] ? com_level_i : '0;
    assign eff_lvl_o[SRC_WDG] = pend_i[SRC_WDG] ? lvl_t'(LVL_TOP) : '0;

    always_comb begin
        ipl_o = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (eff_lvl_o[k] > ipl_o) ipl_o = eff_lvl_o[k];
        end
    end

    // R2: a pending watchdog forces the top level
    a_r2_wdg_top: assert property (@(posedge clk) disable iff (!rst_n)
        pend_i[SRC_WDG] |-> (ipl_o == lvl_t'(LVL_TOP)));
    // R4: timer or engine at a nonzero level keeps the output at or above it
    a_r4_tmr_floor: assert property (@(posedge clk) disable iff (!rst_n)
        pend_i[SRC_TMR] |-> (ipl_o >= tmr_level_i));
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_arb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ack_req_i,
    input  lvl_t                  ack_level_i,
    input  lvl_t                  eff_lvl_i [N_SRC],
    input  logic [N_SRC*ID_W-1:0] arb_id_i,
    output logic                  ack_done_o,
    output logic                  ack_spurious_o,
    output src_t                  ack_src_o,
    output arb_id_t               ack_id_o,
    output logic [N_INT-1:0]      clr_int_o
);
    ack_state_e state_q, state_d;
    lvl_t       lvl_q;
    logic       found_q, found_d;
    src_t       win_src_q, win_src_d;
    arb_id_t    win_id_q, win_id_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: if (ack_req_i) state_d = ACK_CMP;
            ACK_CMP:  state_d = ACK_RESP;
            ACK_RESP: state_d = ACK_IDLE;
            default:  state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    // compare stage: scan every source for the best match at the held level
    always_comb begin
        found_d   = 1'b0;
        win_src_d = '0;
        win_id_d  = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (lvl_q != '0 && eff_lvl_i[k] == lvl_q &&
                (!found_d || arb_id_i[k*ID_W +: ID_W] >= win_id_d)) begin
                found_d   = 1'b1;
                win_src_d = src_t'(k);
                win_id_d  = arb_id_i[k*ID_W +: ID_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q     <= '0;
            found_q   <= 1'b0;
            win_src_q <= '0;
            win_id_q  <= '0;
        end else begin
            if (state_q == ACK_IDLE && ack_req_i) lvl_q <= ack_level_i;
            if (state_q == ACK_CMP) begin
                found_q   <= found_d;
                win_src_q <= win_src_d;
                win_id_q  <= win_id_d;
            end
        end
    end

    always_comb begin
        ack_done_o     = 1'b0;
        ack_spurious_o = 1'b0;
        ack_src_o      = '0;
        ack_id_o       = '0;
        clr_int_o      = '0;
        unique case (state_q)
            ACK_IDLE, ACK_CMP: ;
            ACK_RESP: begin
                ack_done_o     = 1'b1;
                ack_spurious_o = !found_q;
                if (found_q) begin
                    ack_src_o = win_src_q;
                    ack_id_o  = win_id_q;
                    for (int k = 0; k < N_INT; k++) begin
                        if (win_src_q == src_t'(SRC_TMR + k)) clr_int_o[k] = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // R6: accepted request yields done exactly two edges later
    a_r6_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_IDLE && ack_req_i) |=> !ack_done_o ##1 ack_done_o);
    // R6: done lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done_o |=> !ack_done_o);
    // R11: result fields are quiet outside the response
    a_r11_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_done_o |-> (ack_src_o == '0 && ack_id_o == '0 && !ack_spurious_o));
    // R9: spurious response retires nothing
    a_r9_spurious_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done_o && ack_spurious_o) |-> (clr_int_o == '0));
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_arb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_EXT-1:0]      ext_irq_i,
    input  logic                  wdg_pulse_i,
    input  logic                  tmr_pulse_i,
    input  logic                  com_pulse_i,
    input  logic [LVL_W-1:0]      tmr_level_i,
    input  logic [LVL_W-1:0]      com_level_i,
    input  logic [N_SRC*ID_W-1:0] arb_id_i,
    output logic [LVL_W-1:0]      ipl_o,
    input  logic                  ack_req_i,
    input  logic [LVL_W-1:0]      ack_level_i,
    output logic                  ack_done_o,
    output logic                  ack_spurious_o,
    output logic [SRC_W-1:0]      ack_src_o,
    output logic [ID_W-1:0]       ack_id_o
);
    logic [N_SRC-1:0] pend;
    logic [N_INT-1:0] clr_int;
    lvl_t             eff_lvl [N_SRC];

    irq_src_pending u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_irq_i (ext_irq_i),
        .set_i     ({wdg_pulse_i, com_pulse_i, tmr_pulse_i}),
        .clr_i     (clr_int),
        .pend_o    (pend)
    );

    irq_level_map u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend),
        .tmr_level_i (tmr_level_i),
        .com_level_i (com_level_i),
        .eff_lvl_o   (eff_lvl),
        .ipl_o       (ipl_o)
    );

    irq_ack_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ack_req_i      (ack_req_i),
        .ack_level_i    (ack_level_i),
        .eff_lvl_i      (eff_lvl),
        .arb_id_i       (arb_id_i),
        .ack_done_o     (ack_done_o),
        .ack_spurious_o (ack_spurious_o),
        .ack_src_o      (ack_src_o),
        .ack_id_o       (ack_id_o),
        .clr_int_o      (clr_int)
    );

    // R1: nothing pending means level 0
    a_r1_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (ipl_o == '0));
    // R3: a sampled pin keeps the level at or above its own
    a_r3_pin_floor: assert property (@(posedge clk) disable iff (!rst_n)
        pend[N_EXT-1] |-> (ipl_o >= lvl_t'(N_EXT)));
endmodule

// File: tb/test_irq_level_arbiter.sv
`timescale 1ns/1ps
module test_irq_level_arbiter;
    import irq_arb_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                  rst_n;
    logic [N_EXT-1:0]      ext_irq;
    logic                  wdg_pulse, tmr_pulse, com_pulse;
    logic [LVL_W-1:0]      tmr_level, com_level;
    logic [N_SRC*ID_W-1:0] arb_id;
    logic [LVL_W-1:0]      ipl;
    logic                  ack_req;
    logic [LVL_W-1:0]      ack_level;
    logic                  ack_done, ack_spurious;
    logic [SRC_W-1:0]      ack_src;
    logic [ID_W-1:0]       ack_id;

    irq_level_arbiter i_irq_level_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq),
        .wdg_pulse_i(wdg_pulse), .tmr_pulse_i(tmr_pulse), .com_pulse_i(com_pulse),
        .tmr_level_i(tmr_level), .com_level_i(com_level), .arb_id_i(arb_id),
        .ipl_o(ipl), .ack_req_i(ack_req), .ack_level_i(ack_level),
        .ack_done_o(ack_done), .ack_spurious_o(ack_spurious),
        .ack_src_o(ack_src), .ack_id_o(ack_id)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit [N_EXT-1:0] pins_q;
    bit [2:0]       pint;      // 0 timer, 1 engine, 2 watchdog
    int tlev, clev;
    int ids [N_SRC];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int src_lvl(int s);
        if (s < N_EXT) return s + 1;
        if (s == SRC_TMR) return tlev;
        if (s == SRC_COM) return clev;
        return 7;
    endfunction

    function automatic bit src_pend(int s);
        if (s < N_EXT) return pins_q[s];
        return pint[s - N_EXT];
    endfunction

    function automatic int exp_ipl();
        int m = 0;
        for (int s = 0; s < N_SRC; s++)
            if (src_pend(s) && src_lvl(s) > m) m = src_lvl(s);
        return m;
    endfunction

    function automatic int exp_win(int lv);
        int best = -1;
        if (lv == 0) return -1;
        for (int s = 0; s < N_SRC; s++)
            if (src_pend(s) && src_lvl(s) == lv && (best < 0 || ids[s] >= ids[best])) best = s;
        return best;
    endfunction

    task automatic push_cfg();
        tmr_level = LVL_W'(tlev);
        com_level = LVL_W'(clev);
        for (int s = 0; s < N_SRC; s++) arb_id[s*ID_W +: ID_W] = ID_W'(ids[s]);
    endtask

    task automatic cyc();
        @(posedge clk);
        pins_q = ext_irq;
        pint   = pint | {wdg_pulse, com_pulse, tmr_pulse};
        @(negedge clk);
        wdg_pulse = 1'b0; tmr_pulse = 1'b0; com_pulse = 1'b0;
    endtask

    task automatic pulse_src(int s);
        if (s == SRC_TMR) tmr_pulse = 1'b1;
        if (s == SRC_COM) com_pulse = 1'b1;
        if (s == SRC_WDG) wdg_pulse = 1'b1;
    endtask

    task automatic do_ack(input int lv, input bit hold, input bit rearm);
        int w;
        ack_req = 1'b1; ack_level = LVL_W'(lv);
        cyc();
        chk(ack_done == 1'b0, "R6 done low in compare", ack_done, 0);
        if (hold) begin ack_req = 1'b1; ack_level = LVL_W'((lv % 7) + 1); end
        else ack_req = 1'b0;
        w = exp_win(lv);
        cyc();
        ack_req = 1'b0;
        chk(ack_done == 1'b1, "R6 done in response", ack_done, 1);
        if (w < 0) begin
            chk(ack_spurious == 1'b1, "R9 spurious flag", ack_spurious, 1);
            chk(ack_src == '0 && ack_id == '0, "R9 zero result", ack_src, 0);
        end else begin
            chk(ack_spurious == 1'b0, "R7 not spurious", ack_spurious, 0);
            chk(int'(ack_src) == w, "R7 winner source", ack_src, w);
            chk(int'(ack_id) == ids[w], "R7 winner id", ack_id, ids[w]);
        end
        if (w >= N_EXT) begin
            pint[w - N_EXT] = 1'b0;
            if (rearm) pulse_src(w);
        end
        cyc();
        chk(ack_done == 1'b0, "R6 done single cycle", ack_done, 0);
        chk(ack_spurious == 1'b0 && ack_src == '0, "R11 quiet after", ack_src, 0);
        chk(int'(ipl) == exp_ipl(), "R10 retire visible", ipl, exp_ipl());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog timeout actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int off;
        void'($urandom(32'd2024));
        rst_n = 1'b0; ext_irq = '0; wdg_pulse = 0; tmr_pulse = 0; com_pulse = 0;
        ack_req = 0; ack_level = '0; pins_q = '0; pint = '0;
        tlev = 5; clev = 3;
        for (int s = 0; s < N_SRC; s++) ids[s] = s;
        push_cfg();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ipl == '0, "R11 reset ipl", ipl, 0);
        chk(ack_done == 0 && ack_spurious == 0 && ack_src == 0 && ack_id == 0, "R11 reset ack", ack_done, 0);
        rst_n = 1'b1;
        cyc();
        chk(ipl == '0, "R11 idle after reset", ipl, 0);

        // R2 watchdog at top level
        wdg_pulse = 1'b1; cyc();
        chk(ipl == 3'd7, "R2 watchdog level", ipl, 7);
        // R5 held over several cycles
        repeat (4) cyc();
        chk(ipl == 3'd7, "R5 request held", ipl, 7);
        do_ack(7, 0, 0);
        chk(ipl == 3'd0, "R10 watchdog retired", ipl, 0);

        // R3 pins sampled, not latched
        ext_irq = 7'b0000100; cyc();
        chk(ipl == 3'd3, "R3 pin 3 level", ipl, 3);
        ext_irq = '0; cyc();
        chk(ipl == 3'd0, "R3 pin released", ipl, 0);

        // R4 programmable levels and level 0 disable
        tmr_pulse = 1'b1; cyc();
        chk(ipl == 3'd5, "R4 timer level 5", ipl, 5);
        tlev = 2; push_cfg(); cyc();
        chk(ipl == 3'd2, "R4 timer level 2", ipl, 2);
        tlev = 0; push_cfg(); cyc();
        chk(ipl == 3'd0, "R4 level 0 silent", ipl, 0);
        tlev = 2; push_cfg(); cyc();
        do_ack(2, 0, 0);

        // R7 tie at level 4: engine id 12, timer id 9, pin 4 id 5
        tlev = 4; clev = 4; ids[SRC_TMR] = 9; ids[SRC_COM] = 12; ids[3] = 5; push_cfg();
        tmr_pulse = 1'b1; com_pulse = 1'b1; ext_irq = 7'b0001000; cyc();
        chk(ipl == 3'd4, "R1 shared level", ipl, 4);
        do_ack(4, 0, 0);
        chk(ipl == 3'd4, "R7 others remain", ipl, 4);
        do_ack(4, 1, 0);   // R6 busy request ignored
        do_ack(4, 0, 0);
        chk(ipl == 3'd4, "R10 pin not cleared", ipl, 4);
        ext_irq = '0; cyc();
        chk(ipl == 3'd0, "R3 pin gone", ipl, 0);

        // R9 spurious level and level 0
        tmr_pulse = 1'b1; cyc();
        do_ack(6, 0, 0);
        chk(ipl == 3'd4, "R9 nothing cleared", ipl, 4);
        do_ack(0, 0, 0);
        // R10 set in retire cycle keeps pending
        do_ack(4, 0, 1);
        chk(ipl == 3'd4, "R10 set wins", ipl, 4);
        do_ack(4, 0, 0);

        // R7 equal IDs: higher source code wins
        tlev = 2; clev = 2; ids[SRC_TMR] = 3; ids[SRC_COM] = 3; push_cfg();
        tmr_pulse = 1'b1; com_pulse = 1'b1; cyc();
        do_ack(2, 0, 0);
        chk(ipl == 3'd2, "R7 loser stays", ipl, 2);
        do_ack(2, 0, 0);

        // R8 unique levels: lone low-ID source still wins
        for (int s = 0; s < N_SRC; s++) ids[s] = 15 - s;
        tlev = 1; clev = 6; ids[SRC_COM] = 0; push_cfg();
        com_pulse = 1'b1; ext_irq = 7'b0010001; cyc();
        do_ack(6, 0, 0);
        chk(ipl == 3'd5, "R8 unique winner", ipl, 5);
        ext_irq = '0; cyc();

        // random mix
        for (int it = 0; it < 600; it++) begin
            if ($urandom_range(0, 9) == 0) begin
                off = $urandom_range(0, 15);
                for (int s = 0; s < N_SRC; s++) ids[s] = (s * 7 + off) % 16;
                tlev = $urandom_range(0, 7); clev = $urandom_range(0, 7);
                push_cfg();
            end
            ext_irq   = N_EXT'($urandom) & N_EXT'($urandom);
            tmr_pulse = ($urandom_range(0, 3) == 0);
            com_pulse = ($urandom_range(0, 3) == 0);
            wdg_pulse = ($urandom_range(0, 7) == 0);
            cyc();
            chk(int'(ipl) == exp_ipl(), "R1 random ipl", ipl, exp_ipl());
            if ($urandom_range(0, 1) == 1)
                do_ack($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 3) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule